// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over many clock cycles and returns the full 64-bit product. It has one 32-bit adder, a 32-bit register that holds the multiplicand, and a 64-bit product register. The multiplier operand is not kept in a register of its own. It is loaded into the lower half of the product register, and it is used up one bit at a time as the product shifts right.

A request is made by asserting `start_i` while the block is idle, with both operands presented in the same cycle. The block then runs one iteration per operand bit. In each iteration it looks at the lowest bit of the product register. If that bit is set, it adds the multiplicand into the upper half. It then shifts the whole register right by one place, and the carry out of the adder enters at the top. `busy_o` is high while these iterations run. `done_o` pulses for a single cycle when the product is ready. The product stays on `product_o` until the next request is accepted.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A `start_i` sampled high while `busy_o` is low is accepted, and `busy_o` is 1 in the following cycle.
- R3: After a request is accepted, `busy_o` stays high for exactly 32 cycles. In the cycle after the last busy cycle, `done_o` is 1 and `busy_o` is 0.
- R4: When `done_o` is 1, `product_o` equals the unsigned 64-bit product of the multiplicand and multiplier captured at acceptance.
- R5: A `start_i` asserted while `busy_o` is high is ignored. Neither the result nor the timing of the operation in progress changes, and no extra `done_o` pulse appears.
- R6: Operands of zero and of all ones (0xFFFFFFFF) give exact 64-bit products. The adder's carry out is not lost.
- R7: While the block is idle and no request is accepted, `product_o` holds its value.
- R8: A request presented in the same cycle as `done_o` is accepted and starts a new operation immediately.
- R9: `done_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 64 | Unsigned 64-bit product |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next request. The driver provokes this on purpose. It raises `start_i` in the very cycle in which it sees `done_o`, so that operations run back to back. For each result, the scoreboard checks that the popped product is the one expected, that exactly 32 busy cycles came before it, and that the next operation began without a lost cycle. Separate checks pulse `start_i` in the middle of an operation. They confirm that only the original operands are reflected in the result and that no extra completion is reported.

// File: rtl/mul_pkg.sv
package mul_pkg;
  parameter int unsigned OP_W = 32;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned W = mul_pkg::OP_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mul_add.sv
module mul_add #(
  parameter int unsigned W = mul_pkg::OP_W
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] addend_i,
  input  logic         en_i,
  output logic [W:0]   sum_o
);
  // carry kept as bit W
  assign sum_o = {1'b0, acc_i} + {1'b0, (en_i ? addend_i : '0)};
endmodule

// File: rtl/mul_dpath.sv
module mul_dpath #(
  parameter int unsigned W = mul_pkg::OP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W:0]    sum;

  mul_add #(.W(W)) add_i (
    .acc_i   (prod_q[PW-1:W]),
    .addend_i(mcand_q),
    .en_i    (prod_q[0]),
    .sum_o   (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q <= {sum, prod_q[W-1:1]};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned W = mul_pkg::OP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic load, step;

  mul_ctrl #(.W(W)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_dpath #(.W(W)) dpath_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .prod_o  (product_o)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int unsigned W = mul_pkg::OP_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o
);
  logic [31:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 busy_cnt_q <= '0;
    else if (start_i && !busy_o) busy_cnt_q <= '0;
    else if (busy_o)             busy_cnt_q <= busy_cnt_q + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!busy_o && !done_o));

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && busy_cnt_q == W));

  // R3
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  hold_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .product_o(product_o)
);

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;
  localparam int W = 32;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [W-1:0]   mcand_i = '0;
  logic [W-1:0]   mplier_i = '0;
  logic           busy_o, done_o;
  logic [2*W-1:0] product_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [2*W-1:0] exp_q[$];
  int busy_run = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  shift_add_mul #(.W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  function automatic void check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  // monitor: scoreboard pop, busy length, pulse width
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        logic [2*W-1:0] e;
        check(exp_q.size() != 0, "R5 unexpected done", 64'(exp_q.size()), 64'd1);
        if (exp_q.size() != 0) begin
          e = exp_q.pop_front();
          check(product_o == e, "R4/R6 product", product_o, e);
        end
        check(busy_run == W, "R3 busy length", 64'(busy_run), 64'(W));
        check(!busy_o, "R3 busy low at done", 64'(busy_o), 64'd0);
        check(!prev_done, "R9 done width", 64'(prev_done), 64'd0);
      end
      if (busy_o) busy_run++;
      else busy_run = 0;
      prev_done = done_o;
    end
  end

  // driver: call right after a negedge; accepts when idle or in done cycle
  task automatic issue(logic [W-1:0] a, logic [W-1:0] b, bit poke);
    while (busy_o) @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    exp_q.push_back(64'(a) * 64'(b));
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      mcand_i = ~a; mplier_i = b + 3; start_i = 1'b1; // R5 ignored
      @(negedge clk_i);
      start_i = 1'b0;
      mcand_i = $urandom; mplier_i = $urandom;
    end
    while (!done_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(!busy_o && !done_o, "R1 flags", {62'd0, busy_o, done_o}, 64'd0);
    check(product_o == '0, "R1 product", product_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && product_o == '0, "R1 after release", product_o, 64'd0);

    // R6 corners, back to back (R8: start issued in done cycle)
    issue('0, '0, 1'b0);
    issue('1, '1, 1'b0);
    check(busy_o == 1'b0, "R8 idle in done cycle", 64'(busy_o), 64'd0);
    issue('1, '0, 1'b0);
    issue('0, '1, 1'b0);
    issue(32'h1, '1, 1'b0);
    issue('1, 32'h8000_0000, 1'b0);
    issue(32'h8000_0000, 32'h8000_0000, 1'b0);
    // R5 start while busy
    issue(32'd12345, 32'd6789, 1'b1);
    issue('1, '1, 1'b1);
    // random back to back
    for (int i = 0; i < 300; i++) issue($urandom, $urandom, (i % 17) == 0);
    @(negedge clk_i);
    // R7 hold while idle
    begin
      logic [2*W-1:0] held;
      held = product_o;
      mcand_i = 32'hdead_beef; mplier_i = 32'h1234_5678;
      repeat (6) @(negedge clk_i);
      check(product_o == held, "R7 hold", product_o, held);
      check(!busy_o && !done_o, "R7 idle flags", {62'd0, busy_o, done_o}, 64'd0);
    end
    check(exp_q.size() == 0, "R4 all results seen", 64'(exp_q.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule